// File: doc/BRIEF.md
# Half-Step Fractional Clock-Enable Divider

This block derives slower clock-enable streams from one fast clock. Each divider channel takes a ratio field N and produces enable pulses at a rate of 2/(N+2) of the input clock. The ratio can therefore be any half-integer from 1.0 upwards, not only an integer. Each channel adds 2 to an accumulator on every input cycle and compares the sum against a modulus of N+2. A pulse is issued every time the accumulator wraps, so input edges are skipped in a pattern that averages the exact fractional ratio.

Every channel owns a 16-bit control slice. The slices of several channels are packed side by side in one shared write word. A channel produces output only when both its run-permit bit and its clock-enable bit are set. A ratio-only write path lets software retune a channel without touching its other bits. A pinned-ratio bit chooses between the software ratio and a built-in default. A new ratio takes effect only at the end of the current output period, so no runt pulse is emitted. The enable pulses leave the block from flops.

Top module: `halfstep_clk_div`

## Requirements
- R1: With the run-permit and clock-enable bits both set, and the channel starting from the stopped state, let M = N+2. Step i (i = 1, 2, ...) is the i-th rising edge after the edge that stored the starting write. Its enable output, visible after that edge, is 1 exactly when floor(2i/M) differs from floor(2(i-1)/M). Any window of k·M cycles in steady running holds exactly 2k pulses.
- R2: While the clock-enable bit (slice bit 1) is clear, the channel emits no pulse.
- R3: While the run-permit bit (slice bit 0) is clear, the channel is held stopped with its phase cleared, and it emits no pulse.
- R4: Channel k's slice sits at bits [16k+15:16k] of the write and read words. Run-permit is bit 0, clock-enable is bit 1, pinned-ratio is bit 2, and the ratio field is bits [8+RATIO_W-1:8]. All other slice bits read as zero.
- R5: A write with `wr_ratio_only` set replaces only the ratio field of each selected slice. Run-permit, clock-enable and pinned-ratio keep their values.
- R6: When the pinned-ratio bit is clear, the channel divides by the parameter DEF_RATIO, whatever its ratio field holds. When the bit is set, it divides by the ratio field.
- R7: With N = 0 and the channel running, every input cycle carries an enable pulse.
- R8: A ratio change on a running channel does not alter the current output period. The new modulus is adopted at the next wrap.
- R9: After reset, every slice reads zero and no channel pulses.
- R10: A write changes only the slices whose `wr_mask` bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_ratio_only | input | 1 | Write only the ratio fields of the selected slices |
| wr_mask | input | NUM_DIV | Per-slice write select |
| wr_data | input | 16·NUM_DIV | Write word, one 16-bit slice per channel |
| rd_data | output | 16·NUM_DIV | Current contents of all slices |
| clk_en_o | output | NUM_DIV | Registered enable pulse per channel |

## Verification
The bench builds the block with two channels, a 4-bit ratio field and a default ratio of 3. This keeps the full set of moduli from 2 to 17 small enough for a cycle-exact sweep of two full periods each. The second channel runs on the default modulus 5 alongside the first, which exposes any crosstalk between neighbouring slices. The sweep reaches the full-rate case, odd and even moduli, and the largest modulus. It also reaches a retune from modulus 11 to 2, where applying the new ratio too early would show up as a premature pulse.

// File: rtl/hsdiv_pkg.sv
package hsdiv_pkg;
  localparam int SLICE_W   = 16;
  localparam int BIT_REL   = 0;
  localparam int BIT_EN    = 1;
  localparam int BIT_PIN   = 2;
  localparam int RATIO_LSB = 8;
  localparam int RATIO_MAX_W = SLICE_W - RATIO_LSB;

  function automatic logic [SLICE_W-1:0] used_mask(input int ratio_w);
    logic [SLICE_W-1:0] m;
    m = '0;
    m[BIT_REL] = 1'b1;
    m[BIT_EN]  = 1'b1;
    m[BIT_PIN] = 1'b1;
    for (int b = 0; b < ratio_w; b++) m[RATIO_LSB + b] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/hsdiv_ctl_slice.sv
module hsdiv_ctl_slice
  import hsdiv_pkg::*;
#(
  parameter int RATIO_W   = 8,
  parameter int DEF_RATIO = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_full,
  input  logic               wr_ratio,
  input  logic [SLICE_W-1:0] wr_slice,
  output logic [SLICE_W-1:0] slice_q,
  output logic               run_o,
  output logic [RATIO_W-1:0] n_eff_o
);
  localparam logic [SLICE_W-1:0] USED = used_mask(RATIO_W);

  logic               rel_q, en_q, pin_q;
  logic [RATIO_W-1:0] ratio_q;
  logic               unused_rsvd;

  assign unused_rsvd = ^(wr_slice & ~USED);

  always_ff @(posedge clk) begin
    if (rst) begin
      rel_q   <= 1'b0;
      en_q    <= 1'b0;
      pin_q   <= 1'b0;
      ratio_q <= '0;
    end else if (wr_full) begin
      rel_q   <= wr_slice[BIT_REL];
      en_q    <= wr_slice[BIT_EN];
      pin_q   <= wr_slice[BIT_PIN];
      ratio_q <= wr_slice[RATIO_LSB +: RATIO_W];
    end else if (wr_ratio) begin
      ratio_q <= wr_slice[RATIO_LSB +: RATIO_W];
    end
  end

  always_comb begin
    slice_q                        = '0;
    slice_q[BIT_REL]               = rel_q;
    slice_q[BIT_EN]                = en_q;
    slice_q[BIT_PIN]               = pin_q;
    slice_q[RATIO_LSB +: RATIO_W]  = ratio_q;
  end

  assign run_o   = rel_q & en_q;
  assign n_eff_o = pin_q ? ratio_q : RATIO_W'(DEF_RATIO);

  // R5: ratio-only write leaves the control bits alone
  assert_ratio_only_keeps_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_ratio && !wr_full) |=> (slice_q[2:0] == $past(slice_q[2:0])));

  // R10: with no write, the slice holds
  assert_idle_slice_holds_R10: assert property (@(posedge clk) disable iff (rst)
    (!wr_full && !wr_ratio) |=> $stable(slice_q));
endmodule

// File: rtl/hsdiv_accum.sv
module hsdiv_accum #(
  parameter int RATIO_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic [RATIO_W-1:0] n_eff,
  output logic               pulse_o
);
  localparam int AW = RATIO_W + 1;
  localparam logic [AW-1:0] STEP = AW'(2);

  logic [AW-1:0] acc_q, mod_q, mod_new, sum;
  logic          wrap, pulse_q;

  assign mod_new = {1'b0, n_eff} + STEP;
  assign sum     = acc_q + STEP;
  assign wrap    = (sum >= mod_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      mod_q   <= STEP;
      pulse_q <= 1'b0;
    end else if (!run) begin
      acc_q   <= '0;
      mod_q   <= mod_new;
      pulse_q <= 1'b0;
    end else if (wrap) begin
      acc_q   <= sum - mod_q;
      mod_q   <= mod_new;
      pulse_q <= 1'b1;
    end else begin
      acc_q   <= sum;
      pulse_q <= 1'b0;
    end
  end

  assign pulse_o = pulse_q;

  // R1: phase always stays below the active modulus
  assert_acc_below_mod_R1: assert property (@(posedge clk) disable iff (rst)
    acc_q < mod_q);

  // R2 / R3: a stopped channel is silent and its phase is cleared
  assert_stopped_silent_R2: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!pulse_o && acc_q == '0));

  // R7: modulus 2 pulses on every running cycle
  assert_full_rate_R7: assert property (@(posedge clk) disable iff (rst)
    (run && mod_q == STEP) |=> pulse_o);

  // R8: the modulus only moves at a wrap or while stopped
  assert_ratio_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (run && !wrap) |=> $stable(mod_q));
endmodule

// File: rtl/halfstep_clk_div.sv
module halfstep_clk_div
  import hsdiv_pkg::*;
#(
  parameter int NUM_DIV   = 2,
  parameter int RATIO_W   = 8,
  parameter int DEF_RATIO = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic                       wr_ratio_only,
  input  logic [NUM_DIV-1:0]         wr_mask,
  input  logic [NUM_DIV*SLICE_W-1:0] wr_data,
  output logic [NUM_DIV*SLICE_W-1:0] rd_data,
  output logic [NUM_DIV-1:0]         clk_en_o
);
  initial begin
    assert (RATIO_W >= 1 && RATIO_W <= RATIO_MAX_W)
      else $error("RATIO_W out of range");
    assert (DEF_RATIO >= 0 && DEF_RATIO < (1 << RATIO_W))
      else $error("DEF_RATIO out of range");
  end

  for (genvar k = 0; k < NUM_DIV; k++) begin : g_ch
    logic               wr_full, wr_ratio, run;
    logic [RATIO_W-1:0] n_eff;
    logic [SLICE_W-1:0] slice_q;

    assign wr_full  = wr_en & wr_mask[k] & ~wr_ratio_only;
    assign wr_ratio = wr_en & wr_mask[k] &  wr_ratio_only;

    hsdiv_ctl_slice #(.RATIO_W(RATIO_W), .DEF_RATIO(DEF_RATIO)) u_ctl (
      .clk      (clk),
      .rst      (rst),
      .wr_full  (wr_full),
      .wr_ratio (wr_ratio),
      .wr_slice (wr_data[k*SLICE_W +: SLICE_W]),
      .slice_q  (slice_q),
      .run_o    (run),
      .n_eff_o  (n_eff)
    );

    hsdiv_accum #(.RATIO_W(RATIO_W)) u_acc (
      .clk     (clk),
      .rst     (rst),
      .run     (run),
      .n_eff   (n_eff),
      .pulse_o (clk_en_o[k])
    );

    assign rd_data[k*SLICE_W +: SLICE_W] = slice_q;
  end

  // R9: no enable pulse in the cycle after reset
  assert_reset_quiet_R9: assert property (@(posedge clk)
    rst |=> (clk_en_o == '0));
endmodule

// File: tb/halfstep_clk_div_bench.sv
module halfstep_clk_div_bench;
  localparam int NUM_DIV   = 2;
  localparam int RATIO_W   = 4;
  localparam int DEF_RATIO = 3;
  localparam int W         = NUM_DIV * 16;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               wr_en = 1'b0, wr_ratio_only = 1'b0;
  logic [NUM_DIV-1:0] wr_mask = '0;
  logic [W-1:0]       wr_data = '0;
  logic [W-1:0]       rd_data;
  logic [NUM_DIV-1:0] clk_en_o;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  halfstep_clk_div #(.NUM_DIV(NUM_DIV), .RATIO_W(RATIO_W), .DEF_RATIO(DEF_RATIO)) u_halfstep_clk_div (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ratio_only(wr_ratio_only),
    .wr_mask(wr_mask), .wr_data(wr_data), .rd_data(rd_data), .clk_en_o(clk_en_o)
  );

  function automatic logic [15:0] mk(input int ratio, input bit pin, input bit en, input bit rel);
    logic [15:0] s;
    s = '0;
    s[8 +: RATIO_W] = RATIO_W'(ratio);
    s[2] = pin; s[1] = en; s[0] = rel;
    return s;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the capturing edge
  task automatic do_write(input logic [NUM_DIV-1:0] m, input bit ro, input logic [W-1:0] d);
    wr_en = 1'b1; wr_mask = m; wr_ratio_only = ro; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; wr_mask = '0; wr_ratio_only = 1'b0;
  endtask

  task automatic count_pulses(input int ch, input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (clk_en_o[ch]) n++;
    end
  endtask

  task automatic wait_pulse(input int ch, input string tag);
    bit seen = 1'b0;
    for (int i = 0; i < 64 && !seen; i++) begin
      @(negedge clk);
      if (clk_en_o[ch]) seen = 1'b1;
    end
    check(tag, 32'(seen), 32'd1);
  endtask

  initial begin
    int n;
    int m;
    logic exp_p;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 reset slices", rd_data, 32'h0);
    check("R9 reset pulses", 32'(clk_en_o), 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R9 idle after reset", 32'(clk_en_o), 32'h0);

    // R10 / R4: write only slice 1, pinned clear -> default modulus 5
    do_write(2'b10, 1'b0, {mk(9, 0, 1, 1), 16'hFFFF});
    check("R10 slice0 untouched", 32'(rd_data[15:0]), 32'h0);
    check("R4 slice1 layout", 32'(rd_data[31:16]), 32'(mk(9, 0, 1, 1)));
    repeat (4) @(negedge clk);
    count_pulses(1, 50, n);
    check("R6 default ratio rate", n, 20);

    // R1 / R7: exact pattern sweep over every ratio on slice 0
    for (int nr = 0; nr < (1 << RATIO_W); nr++) begin
      m = nr + 2;
      do_write(2'b01, 1'b0, {16'h0, mk(nr, 1, 1, 0)});
      do_write(2'b01, 1'b0, {16'h0, mk(nr, 1, 1, 1)});
      for (int i = 1; i <= 2 * m; i++) begin
        @(negedge clk);
        exp_p = ((2 * i) / m) != ((2 * (i - 1)) / m);
        check(nr == 0 ? "R7 full rate step" : "R1 pattern step", 32'(clk_en_o[0]), 32'(exp_p));
      end
      count_pulses(0, 3 * m, n);
      check("R1 window count", n, 6);
    end

    // R3: run-permit clear holds the channel silent
    do_write(2'b01, 1'b0, {16'h0, mk(4, 1, 1, 0)});
    count_pulses(0, 20, n);
    check("R3 held stopped", n, 0);

    // R2: clock-enable clear keeps the channel silent
    do_write(2'b01, 1'b0, {16'h0, mk(4, 1, 0, 1)});
    count_pulses(0, 20, n);
    check("R2 gated off", n, 0);

    // R5: ratio-only write on slice 1 with junk in the control bits
    do_write(2'b10, 1'b1, {mk(7, 0, 0, 0) | 16'h00F8, 16'hFFFF});
    check("R5 control bits kept", 32'(rd_data[31:16]), 32'(mk(7, 0, 1, 1)));
    check("R10 slice0 kept", 32'(rd_data[15:0]), 32'(mk(4, 1, 0, 1)));
    count_pulses(1, 50, n);
    check("R6 ratio field ignored when not pinned", n, 20);

    // R8: retune from modulus 11 to 2 on a running channel
    do_write(2'b01, 1'b0, {16'h0, mk(9, 1, 1, 0)});
    do_write(2'b01, 1'b0, {16'h0, mk(9, 1, 1, 1)});
    repeat (15) @(negedge clk);
    wait_pulse(0, "R8 pulse before retune");
    do_write(2'b01, 1'b1, {16'h0, mk(0, 0, 0, 0)});
    check("R8 old period kept", 32'(clk_en_o[0]), 32'h0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R8 old period kept", 32'(clk_en_o[0]), 32'h0);
    end
    wait_pulse(0, "R8 boundary pulse");
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check("R8 new ratio after wrap", 32'(clk_en_o[0]), 32'h1);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule